// File: doc/BRIEF.md
# Per-Word PCM Decommutator with Header Formatter

This block turns a frame-synchronized serial PCM bit stream into a stream of 32-bit output words. A per-position word table, held outside the block, describes every word slot in the minor frame. Each slot sets the bit count, the serial bit order, the justification, whether the word is dropped, and whether the frame ends after it. The block presents the slot index it is working on. It reads that slot's 9-bit descriptor in the same cycle and assembles the incoming bits into a word. In 32-bit mode each word is justified into its own 32-bit output. In 16-bit mode each word is justified into a 16-bit half, and two halves are packed into one output.

Each frame can open with a header. The header is a 64-bit BCD time value taken as two 32-bit words. It is followed by a status word that carries the sync status of the previous frame and a running frame count. Either field can be switched on or off on its own. All producers feed a small ordered queue that can accept several words in one cycle. The queue drains one word per cycle onto a valid-qualified output.

Top module: `pcm_word_decom`

## Requirements
- R1: After reset, incoming bits are ignored and nothing is output until the first bit that arrives with `frame_sync` high. That bit is the first bit of word 0.
- R2: The descriptor layout is [4:0] = length minus one, [5] = LSB-first, [6] = left-justify, [7] = suppress, [8] = end of frame. A word completes after exactly length (1..32) accepted bits.
- R3: In MSB-first order the first serial bit of a word becomes its most significant bit. In LSB-first order the first serial bit becomes bit 0.
- R4: When `pack16` is low, each retained word is output as one 32-bit word. If right-justified, the value sits in the low bits. If left-justified, the value is shifted up by 32 minus length.
- R5: When `pack16` is high, every word length must be at most 16. Each retained word is justified into 16 bits (left shift of 16 minus length when left-justified). Two consecutive halves form one output word, with the earlier half in [31:16].
- R6: In 16-bit mode, an unpaired half left over at a frame's end is output as {half, 16'h0000}. This happens when the next frame starts, ahead of that frame's header.
- R7: A word whose suppress bit is set produces no output and does not occupy a half-word slot.
- R8: After a word with the end-of-frame bit completes, the next accepted bit starts a new frame at word 0. The same happens after the word at index NUM_WORDS-1 completes.
- R9: A bit that arrives with `frame_sync` high always starts a new frame at word 0. Any partly assembled word is discarded.
- R10: When `hdr_time_en` is high at a frame's first bit, two header words are output first: `time_bcd[63:32]`, then `time_bcd[31:0]`, sampled at that bit.
- R11: When `hdr_stat_en` is high at a frame's first bit, one status word follows any time words. Its [31:16] is the `sync_status` sampled at the previous frame start (0 for the first frame). Its [15:0] is the number of frames started before this one, modulo 65536.
- R12: With both header enables low, the frame's data words follow the previous frame's words directly, with nothing in between.
- R13: Output words keep the order in which they were produced, one word per cycle at most. `out_valid` is low during and right after reset, and no word is lost while the queue does not overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pack16 | input | 1 | 1: pack two 16-bit halves per output word; 0: one 32-bit word per PCM word |
| hdr_time_en | input | 1 | Insert the two time words at each frame start |
| hdr_stat_en | input | 1 | Insert the status word at each frame start |
| time_bcd | input | 64 | BCD microsecond time of day |
| sync_status | input | 16 | Synchronizer status to report in the next frame's header |
| bit_valid | input | 1 | A serial bit is present this cycle |
| bit_data | input | 1 | Serial bit value |
| frame_sync | input | 1 | With `bit_valid`: this bit is the first bit of a frame |
| prop_addr | output | ADDR_W | Word slot whose descriptor is needed this cycle |
| prop_data | input | 9 | Descriptor of slot `prop_addr`, returned in the same cycle |
| out_valid | output | 1 | `out_data` carries an output word |
| out_data | output | 32 | Output word |

## Verification
Several behaviours are checked by assertions on every cycle: the bit counter stays below the current word length, an end-of-frame word sends the slot index back to 0, the frame counter steps by exactly one per frame start, a 16-bit-mode word never exceeds 16 bits, a frame start leaves no half-word pending, and the queue never overflows. Other behaviours are visible only in the word stream the bench collects. These are the serial bit order, the justification shifts, the pairing and zero-padding of halves, the removal of suppressed words, the header contents, and which status value a frame reports. The bench shows them by comparing whole frames against an arithmetic model, across sweeps of lengths, orders, header settings and both packing modes.

// File: rtl/pcm_decom_pkg.sv
package pcm_decom_pkg;

   // Per-slot descriptor; packed order fixes the 9-bit encoding (eof is bit 8)
   typedef struct packed {
      logic       eof;
      logic       suppress;
      logic       left_just;
      logic       lsb_first;
      logic [4:0] len_m1;
   } word_prop_t;

   localparam int PROP_W = $bits(word_prop_t);
   localparam int WORD_W = 32;
   localparam int HALF_W = 16;

   // push slot order into the output queue (order is behaviour)
   localparam int SLOT_FLUSH = 0;
   localparam int SLOT_TIME_HI = 1;
   localparam int SLOT_TIME_LO = 2;
   localparam int SLOT_STATUS = 3;
   localparam int SLOT_DATA = 4;
   localparam int NUM_SLOTS = 5;

endpackage

// File: rtl/pcm_word_assembler.sv
module pcm_word_assembler
   import pcm_decom_pkg::*;
#(
   parameter int NUM_WORDS = 16,
   localparam int ADDR_W = $clog2(NUM_WORDS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bit_valid,
   input  logic                bit_data,
   input  logic                frame_sync,
   input  word_prop_t          prop,
   output logic [ADDR_W-1:0]   slot_idx,
   output logic                frame_start,
   output logic                word_done,
   output logic [WORD_W-1:0]   word_val,
   output word_prop_t          word_prop
);

   localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(NUM_WORDS - 1);

   if (NUM_WORDS < 4) begin : g_bad_words
      $error("pcm_word_assembler: NUM_WORDS must be at least 4");
   end

   logic                in_frame;
   logic                restart_pend;
   logic [ADDR_W-1:0]   idx_q;
   logic [4:0]          cnt_q;
   logic [WORD_W-1:0]   acc_q;

   logic                take;
   logic                start_now;
   logic [ADDR_W-1:0]   cur_idx;
   logic [4:0]          cur_cnt;
   logic [WORD_W-1:0]   base;
   logic [WORD_W-1:0]   next_acc;
   logic                last_bit;
   logic                at_end;

   always_comb begin
      start_now = bit_valid & (frame_sync | (in_frame & restart_pend));
      take      = bit_valid & (frame_sync | in_frame);
      cur_idx   = start_now ? '0 : idx_q;
      cur_cnt   = start_now ? 5'd0 : cnt_q;
      base      = (cur_cnt == 5'd0) ? '0 : acc_q;
      if (prop.lsb_first)
         next_acc = base | (WORD_W'(bit_data) << cur_cnt);
      else
         next_acc = {base[WORD_W-2:0], bit_data};
      last_bit  = (cur_cnt == prop.len_m1);
      at_end    = prop.eof | (cur_idx == LAST_IDX);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_frame     <= 1'b0;
         restart_pend <= 1'b0;
         idx_q        <= '0;
         cnt_q        <= '0;
         acc_q        <= '0;
      end else if (take) begin
         in_frame <= 1'b1;
         acc_q    <= next_acc;
         if (last_bit) begin
            cnt_q        <= '0;
            idx_q        <= at_end ? '0 : cur_idx + 1'b1;
            restart_pend <= at_end;
         end else begin
            cnt_q        <= cur_cnt + 5'd1;
            idx_q        <= cur_idx;
            restart_pend <= 1'b0;
         end
      end
   end

   assign slot_idx    = cur_idx;
   assign frame_start = start_now;
   assign word_done   = take & last_bit;
   assign word_val    = next_acc;
   assign word_prop   = prop;

   // R1: nothing completes while hunting for the first sync
   a_r1_hunt_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_frame && !frame_sync) |-> !word_done);

   // R2: a running bit count never reaches past the current slot length
   a_r2_count_in_len: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_valid && in_frame && !start_now) |-> (cnt_q <= prop.len_m1));

   // R8: an end-of-frame word returns the slot index to zero
   a_r8_eof_wraps: assert property (@(posedge clk) disable iff (!rst_n)
      (word_done && prop.eof) |=> (idx_q == '0 && restart_pend));

endmodule

// File: rtl/pcm_word_justify.sv
module pcm_word_justify
   import pcm_decom_pkg::*;
(
   input  logic [WORD_W-1:0] val,
   input  logic [4:0]        len_m1,
   input  logic              left_just,
   input  logic              pack16,
   output logic [WORD_W-1:0] field
);

   logic [4:0]          sh32;
   logic [3:0]          sh16;
   logic [WORD_W-1:0]   j32;
   logic [HALF_W-1:0]   j16;

   always_comb begin
      sh32  = 5'd31 - len_m1;
      sh16  = 4'd15 - len_m1[3:0];
      j32   = left_just ? (val << sh32) : val;
      j16   = left_just ? (val[HALF_W-1:0] << sh16) : val[HALF_W-1:0];
      field = pack16 ? {{(WORD_W-HALF_W){1'b0}}, j16} : j32;
   end

endmodule

// File: rtl/pcm_out_queue.sv
module pcm_out_queue
   import pcm_decom_pkg::*;
#(
   parameter int DEPTH  = 16,
   parameter int PUSHES = NUM_SLOTS,
   localparam int PW = $clog2(DEPTH),
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push_v [PUSHES],
   input  logic [WORD_W-1:0] push_d [PUSHES],
   output logic              out_valid,
   output logic [WORD_W-1:0] out_data
);

   if ((DEPTH & (DEPTH - 1)) != 0 || DEPTH < 2) begin : g_bad_depth
      $error("pcm_out_queue: DEPTH must be a power of two, at least 2");
   end
   if (PUSHES > DEPTH) begin : g_bad_push
      $error("pcm_out_queue: PUSHES must not exceed DEPTH");
   end

   logic [WORD_W-1:0] mem [DEPTH];
   logic [PW-1:0]     wr_ptr;
   logic [PW-1:0]     rd_ptr;
   logic [CW-1:0]     count;
   logic [CW-1:0]     off [PUSHES+1];
   logic              pop;

   // running offset of each accepted push within this cycle
   always_comb begin
      off[0] = '0;
      for (int i = 0; i < PUSHES; i++)
         off[i+1] = off[i] + CW'(push_v[i]);
   end

   assign pop = (count != '0);

   always_ff @(posedge clk) begin
      for (int i = 0; i < PUSHES; i++)
         if (push_v[i]) mem[PW'(wr_ptr + PW'(off[i]))] <= push_d[i];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         wr_ptr <= PW'(wr_ptr + PW'(off[PUSHES]));
         rd_ptr <= rd_ptr + PW'(pop);
         count  <= count + off[PUSHES] - CW'(pop);
      end
   end

   assign out_valid = pop;
   assign out_data  = mem[rd_ptr];

   // R13: the pushes of one cycle always fit in the space left
   a_r13_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      (32'(count) + 32'(off[PUSHES])) <= (32'(DEPTH) + 32'(pop)));

   // R13: a waiting word is always delivered on the next edge
   a_r13_drains: assert property (@(posedge clk) disable iff (!rst_n)
      (count != '0) |=> (rd_ptr == PW'($past(rd_ptr) + 1'b1)));

endmodule

// File: rtl/pcm_word_decom.sv
module pcm_word_decom
   import pcm_decom_pkg::*;
#(
   parameter int NUM_WORDS   = 16,
   parameter int QUEUE_DEPTH = 16,
   parameter bit HAS_PACK16  = 1'b1,
   localparam int ADDR_W = $clog2(NUM_WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pack16,
   input  logic              hdr_time_en,
   input  logic              hdr_stat_en,
   input  logic [63:0]       time_bcd,
   input  logic [15:0]       sync_status,
   input  logic              bit_valid,
   input  logic              bit_data,
   input  logic              frame_sync,
   output logic [ADDR_W-1:0] prop_addr,
   input  logic [8:0]        prop_data,
   output logic              out_valid,
   output logic [31:0]       out_data
);

   if (QUEUE_DEPTH < NUM_SLOTS) begin : g_bad_queue
      $error("pcm_word_decom: QUEUE_DEPTH must hold one cycle of pushes");
   end

   word_prop_t          prop_in;
   word_prop_t          wprop;
   logic                frame_start;
   logic                word_done;
   logic [WORD_W-1:0]   word_val;
   logic [WORD_W-1:0]   field;
   logic                mode16;
   logic                keep;
   logic                half_v;
   logic [HALF_W-1:0]   half_d;
   logic                half_after;
   logic [15:0]         stat_prev;
   logic [15:0]         frame_cnt;
   logic                push_v [NUM_SLOTS];
   logic [WORD_W-1:0]   push_d [NUM_SLOTS];

   assign prop_in = word_prop_t'(prop_data);

   pcm_word_assembler #(.NUM_WORDS(NUM_WORDS)) u_asm (
      .clk        (clk),
      .rst_n      (rst_n),
      .bit_valid  (bit_valid),
      .bit_data   (bit_data),
      .frame_sync (frame_sync),
      .prop       (prop_in),
      .slot_idx   (prop_addr),
      .frame_start(frame_start),
      .word_done  (word_done),
      .word_val   (word_val),
      .word_prop  (wprop)
   );

   pcm_word_justify u_just (
      .val      (word_val),
      .len_m1   (wprop.len_m1),
      .left_just(wprop.left_just),
      .pack16   (mode16),
      .field    (field)
   );

   assign keep = word_done & ~wprop.suppress;

   // half-word packer exists only when 16-bit packing is built in
   if (HAS_PACK16) begin : g_pack
      assign mode16     = pack16;
      assign half_after = frame_start ? 1'b0 : half_v;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            half_v <= 1'b0;
            half_d <= '0;
         end else if (keep && mode16) begin
            half_v <= ~half_after;
            if (!half_after) half_d <= field[HALF_W-1:0];
         end else if (frame_start) begin
            half_v <= 1'b0;
         end
      end

      // R5: a packed word never carries more than 16 bits
      a_r5_len_fits_half: assert property (@(posedge clk) disable iff (!rst_n)
         (word_done && mode16) |-> (wprop.len_m1 < 5'd16));

      // R6: after a frame start no stale half is left over
      a_r6_start_clears_half: assert property (@(posedge clk) disable iff (!rst_n)
         frame_start |=> (!half_v || $past(keep && mode16)));
   end else begin : g_nopack
      assign mode16     = 1'b0;
      assign half_after = 1'b0;
      assign half_v     = 1'b0;
      assign half_d     = '0;
   end

   // header state: status of the previous frame and frames started so far
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_prev <= '0;
         frame_cnt <= '0;
      end else if (frame_start) begin
         stat_prev <= sync_status;
         frame_cnt <= frame_cnt + 16'd1;
      end
   end

   // push list in output order: flush, time hi, time lo, status, data
   always_comb begin
      push_v[SLOT_FLUSH]   = frame_start & half_v;
      push_d[SLOT_FLUSH]   = {half_d, {HALF_W{1'b0}}};
      push_v[SLOT_TIME_HI] = frame_start & hdr_time_en;
      push_d[SLOT_TIME_HI] = time_bcd[63:32];
      push_v[SLOT_TIME_LO] = frame_start & hdr_time_en;
      push_d[SLOT_TIME_LO] = time_bcd[31:0];
      push_v[SLOT_STATUS]  = frame_start & hdr_stat_en;
      push_d[SLOT_STATUS]  = {stat_prev, frame_cnt};
      push_v[SLOT_DATA]    = keep & (mode16 ? half_after : 1'b1);
      push_d[SLOT_DATA]    = mode16 ? {half_d, field[HALF_W-1:0]} : field;
   end

   pcm_out_queue #(.DEPTH(QUEUE_DEPTH), .PUSHES(NUM_SLOTS)) u_q (
      .clk      (clk),
      .rst_n    (rst_n),
      .push_v   (push_v),
      .push_d   (push_d),
      .out_valid(out_valid),
      .out_data (out_data)
   );

   // R11: the frame count advances by exactly one per frame start
   a_r11_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |=> (frame_cnt == $past(frame_cnt) + 16'd1));

   // R11: the count holds between frame starts
   a_r11_count_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_start |=> $stable(frame_cnt));

endmodule

// File: tb/test_pcm_word_decom.sv
module test_pcm_word_decom;

   localparam int NW = 16;
   localparam int MAXQ = 4096;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        pack16, hdr_time_en, hdr_stat_en;
   logic [63:0] time_bcd;
   logic [15:0] sync_status;
   logic        bit_valid, bit_data, frame_sync;
   logic [3:0]  prop_addr;
   logic [8:0]  prop_data;
   logic        out_valid;
   logic [31:0] out_data;

   always #10 clk = ~clk;

   logic [8:0] ptab [NW];
   assign prop_data = ptab[prop_addr];

   pcm_word_decom #(.NUM_WORDS(NW), .QUEUE_DEPTH(16)) i_pcm_word_decom (
      .clk(clk), .rst_n(rst_n), .pack16(pack16), .hdr_time_en(hdr_time_en),
      .hdr_stat_en(hdr_stat_en), .time_bcd(time_bcd), .sync_status(sync_status),
      .bit_valid(bit_valid), .bit_data(bit_data), .frame_sync(frame_sync),
      .prop_addr(prop_addr), .prop_data(prop_data),
      .out_valid(out_valid), .out_data(out_data)
   );

   int          vectors = 0;
   int          miscompares = 0;
   bit          finished = 0;
   logic [31:0] got [MAXQ];
   logic [31:0] expq [MAXQ];
   int          got_n = 0;
   int          exp_n = 0;

   // model state
   bit          m_hv = 0;
   logic [15:0] m_hd = '0;
   logic [15:0] m_stat = '0;
   logic [15:0] m_cnt = '0;
   logic [31:0] seed = 32'h1ACE_B00C;

   always @(negedge clk)
      if (rst_n === 1'b1 && out_valid === 1'b1 && got_n < MAXQ) begin
         got[got_n] = out_data;
         got_n++;
      end

   task automatic push_e(input logic [31:0] w);
      if (exp_n < MAXQ) expq[exp_n] = w;
      exp_n++;
   endtask

   task automatic tick(input logic v, input logic b, input logic s);
      @(negedge clk);
      bit_valid = v;
      bit_data = b;
      frame_sync = s;
   endtask

   task automatic idle(input int n);
      repeat (n) tick(1'b0, 1'b0, 1'b0);
   endtask

   task automatic load_table(input int c);
      for (int i = 0; i < NW; i++) begin
         int len;
         int eof_at;
         len = (c % 2 == 1) ? ((c * 3 + i * 5) % 16) + 1 : ((c * 7 + i * 11) % 32) + 1;
         eof_at = (c % 3 == 0) ? -1 : 3 + (c % 7);
         ptab[i] = {(i == eof_at) ? 1'b1 : 1'b0,
                    ((i + c) % 6 == 4) ? 1'b1 : 1'b0,
                    1'(((i >> 1) ^ c) & 1),
                    1'((i ^ c) & 1),
                    5'(len - 1)};
      end
   endtask

   // R6 R10 R11 R12: what a frame start must emit before its data
   task automatic model_frame_start();
      if (m_hv) push_e({m_hd, 16'h0000});
      m_hv = 0;
      if (hdr_time_en) begin
         push_e(time_bcd[63:32]);
         push_e(time_bcd[31:0]);
      end
      if (hdr_stat_en) push_e({m_stat, m_cnt});
      m_stat = sync_status;
      m_cnt = m_cnt + 16'd1;
   endtask

   task automatic run_frame(input bit use_sync, input int abort_at);
      int  i = 0;
      bit  done = 0;
      bit  first = 1;
      model_frame_start();
      while (!done) begin
         logic [8:0]  p;
         logic [31:0] v;
         logic [31:0] j32;
         logic [15:0] j16;
         int          len;
         int          nb;
         p = ptab[i];
         len = int'(p[4:0]) + 1;
         seed = seed * 32'd1103515245 + 32'd12345;
         v = (len == 32) ? (seed ^ (seed >> 7)) : ((seed ^ (seed >> 7)) & ((32'd1 << len) - 32'd1));
         nb = (i == abort_at) ? len - 1 : len;
         for (int k = 0; k < nb; k++) begin
            // R3: LSB-first sends bit k first, MSB-first sends the top bit first
            tick(1'b1, p[5] ? v[k] : v[len-1-k], first & use_sync);
            first = 0;
            if (k % 3 == 2) idle(1);
         end
         if (i == abort_at) begin
            done = 1;                      // R9: partial word must vanish
         end else begin
            if (!p[7]) begin               // R7: suppressed words add nothing
               j32 = p[6] ? (v << (32 - len)) : v;
               j16 = p[6] ? 16'(v << (16 - len)) : v[15:0];
               if (pack16) begin           // R5: earlier half on top
                  if (m_hv) begin
                     push_e({m_hd, j16});
                     m_hv = 0;
                  end else begin
                     m_hv = 1;
                     m_hd = j16;
                  end
               end else begin              // R4
                  push_e(j32);
               end
            end
            if (p[8] || i == NW - 1) done = 1;   // R8
            i++;
         end
      end
   endtask

   task automatic check_stream(input string tag);
      idle(40);
      vectors++;
      if (got_n != exp_n) begin
         miscompares++;
         $display("FAIL R13 %s: word count actual=%0d expected=%0d", tag, got_n, exp_n);
      end
      for (int i = 0; i < got_n && i < exp_n && i < MAXQ; i++) begin
         vectors++;
         if (got[i] !== expq[i]) begin
            miscompares++;
            $display("FAIL %s word %0d: actual=%08h expected=%08h", tag, i, got[i], expq[i]);
         end
      end
      got_n = 0;
      exp_n = 0;
   endtask

   initial begin
      rst_n = 1'b0;
      pack16 = 1'b0;
      hdr_time_en = 1'b0;
      hdr_stat_en = 1'b0;
      time_bcd = '0;
      sync_status = '0;
      bit_valid = 1'b0;
      bit_data = 1'b0;
      frame_sync = 1'b0;
      load_table(0);
      repeat (3) @(negedge clk);
      vectors++;
      if (out_valid !== 1'b0) begin
         miscompares++;
         $display("FAIL R13 reset: out_valid actual=%b expected=0", out_valid);
      end
      rst_n = 1'b1;
      idle(2);

      // R1: bits before any sync are dropped
      for (int k = 0; k < 12; k++) tick(1'b1, 1'(k & 1), 1'b0);
      idle(20);
      vectors++;
      if (got_n != 0) begin
         miscompares++;
         $display("FAIL R1 unsynced bits: outputs actual=%0d expected=0", got_n);
      end
      got_n = 0;

      for (int c = 0; c < 12; c++) begin
         bit aborted = 0;
         load_table(c);
         pack16 = c[0];
         hdr_time_en = c[1];
         hdr_stat_en = c[2] ^ c[3];
         for (int f = 0; f < 3; f++) begin
            int ab;
            time_bcd = {16'h2024, 8'(c), 8'(f), 16'h0000, 8'(c * 3 + f), 8'h59};
            sync_status = 16'hA000 | 16'(c * 16 + f);
            ab = (f == 1 && c % 4 == 1) ? 2 : -1;
            run_frame(f == 0 || aborted, ab);
            aborted = (ab >= 0);
         end
         check_stream($sformatf("R2 R3 R4 R5 R6 R7 R8 R9 R10 R11 R12 cfg=%0d", c));
      end

      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      #(64'd200000 * 20);
      if (!finished) begin
         miscompares++;
         $display("FAIL R13 watchdog: actual=hung expected=done");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

endmodule